// File: doc/BRIEF.md
# Commit Hold Controller for Speculative and Forwarding-Only Function Units

This block decides, for each function unit of an out-of-order core, when that unit may write its result to the register file, when it must be cancelled, and when it may throw its result away without writing it. Each unit that can still raise an exception holds back every younger unit that depends on it. When such a unit reports that it can no longer fault, its hold is lifted. When it does fault, every unit it was holding back is cancelled in the same step.

A unit whose destination register has been overwritten by a younger instruction can be marked as forwarding-only. Its result then reaches its consumers only through the bypass path and is never written back. The controller keeps such a unit alive until every consumer that took its forwarded value has been declared exception-free. Only then does it allow the value to be dropped. If any of those consumers is cancelled or faults, the unit becomes an ordinary unit again and raises a write-back request. It holds that request until the write port grants it.

The issue logic supplies three things at issue time: the older units that may fault, and the older units whose forwarded results the new instruction consumes. It also marks producers as forwarding-only when their destination is overwritten. All per-unit vectors use bit i for unit i.

Top module: `chc_commit_hold`

## Requirements
- R1: `commit_ok[i]` is 1 exactly when unit i is busy, is not forwarding-only, and has no pending hold from an older unit. A `wr_grant[i]` given while `commit_ok[i]` is 0 has no effect.
- R2: On issue, the new unit is held by every unit listed in `issue_shadow`. It is also held by every unit that was holding any of those listed units, counting only units that are busy.
- R3: A `clear_pulse[j]` lifts unit j's hold from all units at that clock edge. A unit with no hold left shows `commit_ok` in the next cycle.
- R4: A `fault_pulse[j]` on busy unit j puts a one-cycle `kill` pulse, in the next cycle, on every busy unit that unit j was holding. The killed units and unit j all become idle.
- R5: `nameless_set[i]` on a busy unit in the ordinary state makes it forwarding-only from the next cycle. A forwarding-only unit never shows `commit_ok`.
- R6: A forwarding-only unit asserts `discard_ok` for one cycle and becomes idle. This happens one cycle after it has no hold left and every consumer that took its value has cleared. Issuing a consumer never releases the producer by itself.
- R7: If a consumer of a forwarding-only unit is killed or faults, the producer returns to the ordinary state and raises `wb_req`. It holds `wb_req` until granted. A producer that was never forwarding-only raises no `wb_req` in that case.
- R8: A `wr_grant[i]` while `commit_ok[i]` is 1 makes unit i idle from the next cycle.
- R9: An issue to a unit that is already busy is ignored.
- R10: After a synchronous reset, all outputs are 0 and all units are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_en | input | 1 | Issue an instruction to unit `issue_fu` |
| issue_fu | input | IDX_W | Index of the unit being issued |
| issue_shadow | input | NUM_FU | Older units that may still fault and hold the new unit |
| issue_fwd | input | NUM_FU | Older units whose forwarded result the new unit consumes |
| clear_pulse | input | NUM_FU | Unit can no longer raise an exception |
| fault_pulse | input | NUM_FU | Unit raised an exception |
| nameless_set | input | NUM_FU | Mark unit as forwarding-only |
| wr_grant | input | NUM_FU | Register file write granted to unit |
| commit_ok | output | NUM_FU | Unit may write its result |
| kill | output | NUM_FU | Unit is cancelled (one-cycle pulse) |
| discard_ok | output | NUM_FU | Forwarding-only unit drops its result (one-cycle pulse) |
| wb_req | output | NUM_FU | Reverted unit requests a register file write |

## Verification
Some rules are checked by assertions on every cycle: kill and discard last exactly one cycle, `wb_req` stays up until a grant, a granted unit retires, an issue to a busy unit leaves it untouched, and reset leaves every output clear. Other rules can only be shown by the bench scenarios. These are that forwarding-only producers wait on their consumers' exception status rather than on issue, that transitive holds survive the clearing of an intermediate unit, and that a fault in the middle of a register-overwrite chain turns the overwritten producer back into a writer. A behavioural model in the bench also follows all outputs on every cycle.

// File: rtl/chc_pkg.sv
package chc_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE     = 2'd0,
    SLOT_NAMED    = 2'd1,
    SLOT_NAMELESS = 2'd2,
    SLOT_REVERT   = 2'd3
  } slot_st_e;
endpackage

// File: rtl/chc_shadow_matrix.sv
module chc_shadow_matrix #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_ok,
  input  logic [IDX_W-1:0] issue_fu,
  input  logic [N-1:0]     issue_mask,
  input  logic [N-1:0]     busy,
  input  logic [N-1:0]     fault,
  input  logic [N-1:0]     clr_col,
  input  logic [N-1:0]     go_idle,
  output logic [N-1:0]     blocked,
  output logic [N-1:0]     kill_now
);
  localparam logic [N-1:0] ONE = N'(1);

  // row i, bit j: unit j holds unit i
  logic [N-1:0] hold [N];
  logic [N-1:0] closure;

  always_comb begin
    closure = issue_mask;
    for (int j = 0; j < N; j++)
      if (issue_mask[j]) closure = closure | hold[j];
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      blocked[i]  = |hold[i];
      kill_now[i] = busy[i] & (|(hold[i] & fault));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) hold[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (go_idle[i])
          hold[i] <= '0;
        else if (issue_ok && issue_fu == IDX_W'(i))
          hold[i] <= closure & busy & ~clr_col & ~(ONE << i);
        else
          hold[i] <= hold[i] & ~clr_col;
      end
    end
  end
endmodule

// File: rtl/chc_link_matrix.sv
module chc_link_matrix #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_ok,
  input  logic [IDX_W-1:0] issue_fu,
  input  logic [N-1:0]     fwd_mask,
  input  logic [N-1:0]     busy,
  input  logic [N-1:0]     clr_col,
  input  logic [N-1:0]     go_idle,
  input  logic [N-1:0]     dead,
  output logic [N-1:0]     has_link,
  output logic [N-1:0]     lost_cons
);
  localparam logic [N-1:0] ONE = N'(1);

  // row p, bit c: consumer c took the forwarded value of producer p
  logic [N-1:0] link [N];

  always_comb begin
    for (int p = 0; p < N; p++) begin
      has_link[p]  = |link[p];
      lost_cons[p] = |(link[p] & dead);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < N; p++) link[p] <= '0;
    end else begin
      for (int p = 0; p < N; p++) begin
        if (go_idle[p])
          link[p] <= '0;
        else if (issue_ok && fwd_mask[p] && busy[p])
          link[p] <= (link[p] & ~clr_col) | (ONE << issue_fu);
        else
          link[p] <= link[p] & ~clr_col;
      end
    end
  end
endmodule

// File: rtl/chc_fu_slot.sv
module chc_fu_slot
  import chc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic issue_hit,
  input  logic mark_nl,
  input  logic grant,
  input  logic blocked,
  input  logic kill_now,
  input  logic fault,
  input  logic has_link,
  input  logic lost_cons,
  output logic busy,
  output logic dead,
  output logic go_idle,
  output logic commit_ok,
  output logic kill_q,
  output logic disc_q,
  output logic wb_req
);
  slot_st_e st;
  logic     is_named;
  logic     disc;
  logic     revert;
  logic     retire;

  assign busy     = (st != SLOT_IDLE);
  assign is_named = (st == SLOT_NAMED) || (st == SLOT_REVERT);
  assign dead     = busy & (fault | kill_now);
  assign disc     = (st == SLOT_NAMELESS) & ~has_link & ~blocked & ~dead;
  assign revert   = (st == SLOT_NAMELESS) & lost_cons & ~dead;
  assign retire   = is_named & ~blocked & grant & ~dead;
  assign go_idle  = dead | disc | retire;

  assign commit_ok = is_named & ~blocked;
  assign wb_req    = (st == SLOT_REVERT) & ~blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SLOT_IDLE;
      kill_q <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      kill_q <= busy & kill_now;
      disc_q <= disc;
      if (go_idle)
        st <= SLOT_IDLE;
      else if (issue_hit)
        st <= SLOT_NAMED;
      else if (revert)
        st <= SLOT_REVERT;
      else if (mark_nl && st == SLOT_NAMED)
        st <= SLOT_NAMELESS;
    end
  end
endmodule

// File: rtl/chc_commit_hold.sv
module chc_commit_hold #(
  parameter  int NUM_FU = 4,
  localparam int IDX_W  = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_en,
  input  logic [IDX_W-1:0]  issue_fu,
  input  logic [NUM_FU-1:0] issue_shadow,
  input  logic [NUM_FU-1:0] issue_fwd,
  input  logic [NUM_FU-1:0] clear_pulse,
  input  logic [NUM_FU-1:0] fault_pulse,
  input  logic [NUM_FU-1:0] nameless_set,
  input  logic [NUM_FU-1:0] wr_grant,
  output logic [NUM_FU-1:0] commit_ok,
  output logic [NUM_FU-1:0] kill,
  output logic [NUM_FU-1:0] discard_ok,
  output logic [NUM_FU-1:0] wb_req
);
  logic [NUM_FU-1:0] busy, dead, go_idle, blocked, kill_now;
  logic [NUM_FU-1:0] has_link, lost_cons, clr_col;
  logic              issue_ok;

  assign issue_ok = issue_en & ~busy[issue_fu];
  assign clr_col  = clear_pulse | go_idle;

  chc_shadow_matrix #(.N(NUM_FU), .IDX_W(IDX_W)) u_shadow (
    .clk(clk), .rst(rst), .issue_ok(issue_ok), .issue_fu(issue_fu),
    .issue_mask(issue_shadow), .busy(busy), .fault(fault_pulse),
    .clr_col(clr_col), .go_idle(go_idle),
    .blocked(blocked), .kill_now(kill_now)
  );

  chc_link_matrix #(.N(NUM_FU), .IDX_W(IDX_W)) u_link (
    .clk(clk), .rst(rst), .issue_ok(issue_ok), .issue_fu(issue_fu),
    .fwd_mask(issue_fwd), .busy(busy), .clr_col(clr_col),
    .go_idle(go_idle), .dead(dead),
    .has_link(has_link), .lost_cons(lost_cons)
  );

  for (genvar g = 0; g < NUM_FU; g++) begin : g_slot
    chc_fu_slot u_slot (
      .clk(clk), .rst(rst),
      .issue_hit(issue_ok && issue_fu == IDX_W'(g)),
      .mark_nl(nameless_set[g]), .grant(wr_grant[g]),
      .blocked(blocked[g]), .kill_now(kill_now[g]),
      .fault(fault_pulse[g]), .has_link(has_link[g]),
      .lost_cons(lost_cons[g]),
      .busy(busy[g]), .dead(dead[g]), .go_idle(go_idle[g]),
      .commit_ok(commit_ok[g]), .kill_q(kill[g]),
      .disc_q(discard_ok[g]), .wb_req(wb_req[g])
    );
  end
endmodule

// File: rtl/chc_commit_hold_chk.sv
module chc_commit_hold_chk #(
  parameter  int NUM_FU = 4,
  localparam int IDX_W  = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_en,
  input logic [IDX_W-1:0]  issue_fu,
  input logic [NUM_FU-1:0] fault_pulse,
  input logic [NUM_FU-1:0] nameless_set,
  input logic [NUM_FU-1:0] wr_grant,
  input logic [NUM_FU-1:0] commit_ok,
  input logic [NUM_FU-1:0] kill,
  input logic [NUM_FU-1:0] discard_ok,
  input logic [NUM_FU-1:0] wb_req
);
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (commit_ok == '0 && kill == '0 && discard_ok == '0 && wb_req == '0)); // R10

  for (genvar i = 0; i < NUM_FU; i++) begin : g_chk
    AST_WB_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (rst)
      wb_req[i] |-> commit_ok[i]); // R7
    AST_WB_HELD: assert property (@(posedge clk) disable iff (rst)
      wb_req[i] && !wr_grant[i] && !fault_pulse[i] |=> wb_req[i]); // R7
    AST_GRANT_RETIRES: assert property (@(posedge clk) disable iff (rst)
      commit_ok[i] && wr_grant[i] && !fault_pulse[i] |=> !commit_ok[i]); // R8
    AST_KILL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      kill[i] |=> !kill[i]); // R4
    AST_KILL_IDLE: assert property (@(posedge clk) disable iff (rst)
      kill[i] |-> !commit_ok[i] && !wb_req[i]); // R4
    AST_DISCARD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      discard_ok[i] |=> !discard_ok[i]); // R6
    AST_DISCARD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
      discard_ok[i] |-> !commit_ok[i]); // R6
    AST_BUSY_ISSUE_IGNORED: assert property (@(posedge clk) disable iff (rst)
      commit_ok[i] && issue_en && issue_fu == IDX_W'(i) && !wr_grant[i]
      && !fault_pulse[i] && !nameless_set[i] |=> commit_ok[i]); // R9
  end
endmodule

bind chc_commit_hold chc_commit_hold_chk #(.NUM_FU(NUM_FU)) u_chk (
  .clk(clk), .rst(rst), .issue_en(issue_en), .issue_fu(issue_fu),
  .fault_pulse(fault_pulse), .nameless_set(nameless_set),
  .wr_grant(wr_grant), .commit_ok(commit_ok), .kill(kill),
  .discard_ok(discard_ok), .wb_req(wb_req)
);

// File: tb/sim_chc_commit_hold.sv
module sim_chc_commit_hold;
  localparam int N     = 4;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         issue_en = 1'b0;
  logic [1:0]   issue_fu = '0;
  logic [N-1:0] issue_shadow = '0, issue_fwd = '0, clear_pulse = '0;
  logic [N-1:0] fault_pulse = '0, nameless_set = '0, wr_grant = '0;
  logic [N-1:0] commit_ok, kill, discard_ok, wb_req;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 0;

  always #(CLK_P/2) clk = ~clk;

  chc_commit_hold #(.NUM_FU(N)) u0 (
    .clk(clk), .rst(rst), .issue_en(issue_en), .issue_fu(issue_fu),
    .issue_shadow(issue_shadow), .issue_fwd(issue_fwd),
    .clear_pulse(clear_pulse), .fault_pulse(fault_pulse),
    .nameless_set(nameless_set), .wr_grant(wr_grant),
    .commit_ok(commit_ok), .kill(kill), .discard_ok(discard_ok),
    .wb_req(wb_req)
  );

  // behavioural reference: 0 idle, 1 ordinary, 2 forwarding-only, 3 reverted
  int           m_st [N];
  bit [N-1:0]   m_hold [N];
  bit [N-1:0]   m_link [N];
  bit [N-1:0]   m_kill, m_disc;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_st[i] = 0; m_hold[i] = '0; m_link[i] = '0;
      end
      m_kill = '0; m_disc = '0;
    end else begin
      bit [N-1:0] bsy, kn, dd, dsc, rv, rt, idle, clr, clo;
      bit         iss;
      int         nst [N];
      bit [N-1:0] nh [N];
      bit [N-1:0] nlk [N];
      for (int i = 0; i < N; i++) begin
        bsy[i] = (m_st[i] != 0);
        kn[i]  = bsy[i] && ((m_hold[i] & fault_pulse) != 0);
        dd[i]  = bsy[i] && (fault_pulse[i] || kn[i]);
      end
      for (int i = 0; i < N; i++) begin
        dsc[i] = (m_st[i] == 2) && m_link[i] == 0 && m_hold[i] == 0 && !dd[i];
        rv[i]  = (m_st[i] == 2) && ((m_link[i] & dd) != 0) && !dd[i];
        rt[i]  = (m_st[i] == 1 || m_st[i] == 3) && m_hold[i] == 0 && wr_grant[i] && !dd[i];
      end
      idle = dd | dsc | rt;
      clr  = clear_pulse | idle;
      iss  = issue_en && !bsy[issue_fu];
      clo  = issue_shadow;
      for (int j = 0; j < N; j++) if (issue_shadow[j]) clo |= m_hold[j];
      for (int i = 0; i < N; i++) begin
        nst[i] = m_st[i];
        if (idle[i]) begin
          nst[i] = 0; nh[i] = '0; nlk[i] = '0;
        end else begin
          nh[i]  = m_hold[i] & ~clr;
          nlk[i] = m_link[i] & ~clr;
          if (iss && issue_fwd[i] && bsy[i]) nlk[i][issue_fu] = 1'b1;
          if (iss && int'(issue_fu) == i) begin
            nst[i] = 1;
            nh[i]  = clo & bsy & ~clr;
            nh[i][i] = 1'b0;
          end else if (rv[i]) nst[i] = 3;
          else if (nameless_set[i] && m_st[i] == 1) nst[i] = 2;
        end
      end
      for (int i = 0; i < N; i++) begin
        m_st[i] = nst[i]; m_hold[i] = nh[i]; m_link[i] = nlk[i];
      end
      m_kill = kn; m_disc = dsc;
    end
  end

  task automatic cmp(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit [N-1:0] eco, ewb;
      for (int i = 0; i < N; i++) begin
        eco[i] = (m_st[i] == 1 || m_st[i] == 3) && m_hold[i] == 0;
        ewb[i] = (m_st[i] == 3) && m_hold[i] == 0;
      end
      cmp("R1 model commit_ok", commit_ok, eco);
      cmp("R4 model kill", kill, m_kill);
      cmp("R6 model discard_ok", discard_ok, m_disc);
      cmp("R7 model wb_req", wb_req, ewb);
    end
  end

  task automatic cyc(input logic ie, input logic [1:0] fu,
                     input logic [N-1:0] sh, fw, cl, ft, nl, gr);
    issue_en = ie; issue_fu = fu; issue_shadow = sh; issue_fwd = fw;
    clear_pulse = cl; fault_pulse = ft; nameless_set = nl; wr_grant = gr;
    @(negedge clk);
    issue_en = 1'b0; issue_fu = '0; issue_shadow = '0; issue_fwd = '0;
    clear_pulse = '0; fault_pulse = '0; nameless_set = '0; wr_grant = '0;
  endtask

  task automatic idle_cyc();
    cyc(1'b0, 2'd0, '0, '0, '0, '0, '0, '0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp("R10 reset commit_ok", commit_ok, 4'b0000);
    cmp("R10 reset kill", kill, 4'b0000);
    cmp("R10 reset discard_ok", discard_ok, 4'b0000);
    cmp("R10 reset wb_req", wb_req, 4'b0000);

    // chain A: r1 <- FU0, r2 <- FU1 (reads FU0), r1 <- FU2; FU1 clears
    cyc(1, 2'd0, 4'b0000, 4'b0000, 0, 0, 0, 0);
    cmp("R1 unheld unit may commit", commit_ok, 4'b0001);
    cyc(0, 2'd0, 0, 0, 4'b0001, 0, 0, 0);
    cyc(1, 2'd1, 4'b0000, 4'b0001, 0, 0, 0, 0);
    cmp("R1 two ordinary units", commit_ok, 4'b0011);
    cyc(1, 2'd2, 4'b0010, 4'b0000, 0, 0, 4'b0001, 0);
    cmp("R5 forwarding-only and held units blocked", commit_ok, 4'b0010);
    cmp("R6 consumer issue does not release", discard_ok, 4'b0000);
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 4'b0100);
    cmp("R1 grant to held unit ignored", commit_ok, 4'b0010);
    cyc(0, 2'd0, 0, 0, 4'b0010, 0, 0, 0);
    cmp("R3 clear releases dependent", commit_ok, 4'b0110);
    cmp("R6 discard not yet", discard_ok, 4'b0000);
    idle_cyc();
    cmp("R6 discard after consumer clear", discard_ok, 4'b0001);
    idle_cyc();
    cmp("R6 discard is one cycle", discard_ok, 4'b0000);
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 4'b0110);
    cmp("R8 granted units retire", commit_ok, 4'b0000);

    // chain B: same chain, FU1 faults
    cyc(1, 2'd0, 4'b0000, 4'b0000, 0, 0, 0, 0);
    cyc(0, 2'd0, 0, 0, 4'b0001, 0, 0, 0);
    cyc(1, 2'd1, 4'b0000, 4'b0001, 0, 0, 0, 0);
    cyc(1, 2'd2, 4'b0010, 4'b0000, 0, 0, 4'b0001, 0);
    cyc(0, 2'd0, 0, 0, 0, 4'b0010, 0, 0);
    cmp("R4 held unit killed", kill, 4'b0100);
    cmp("R7 producer reverts to write-back", wb_req, 4'b0001);
    cmp("R7 reverted producer may commit", commit_ok, 4'b0001);
    idle_cyc();
    cmp("R4 kill is one cycle", kill, 4'b0000);
    cmp("R7 wb_req held without grant", wb_req, 4'b0001);
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 4'b0001);
    cmp("R7 wb_req drops after grant", wb_req, 4'b0000);
    cmp("R8 reverted unit idle", commit_ok, 4'b0000);

    // transitive holds
    cyc(1, 2'd0, 4'b0000, 0, 0, 0, 0, 0);
    cyc(1, 2'd1, 4'b0001, 0, 0, 0, 0, 0);
    cmp("R2 direct hold", commit_ok, 4'b0001);
    cyc(1, 2'd2, 4'b0010, 0, 0, 0, 0, 0);
    cyc(0, 2'd0, 0, 0, 4'b0010, 0, 0, 0);
    cmp("R2 inherited hold survives middle clear", commit_ok, 4'b0001);
    cyc(0, 2'd0, 0, 0, 0, 4'b0001, 0, 0);
    cmp("R2 R4 fault kills inherited dependents", kill, 4'b0110);
    cmp("R4 all idle after fault", commit_ok, 4'b0000);
    idle_cyc();

    // busy issue and ordinary producer with faulting consumer
    cyc(1, 2'd3, 0, 0, 0, 0, 0, 0);
    cyc(1, 2'd0, 0, 0, 0, 0, 0, 0);
    cmp("R1 two independent units", commit_ok, 4'b1001);
    cyc(1, 2'd3, 4'b0001, 0, 0, 0, 0, 0);
    cmp("R9 issue to busy unit ignored", commit_ok, 4'b1001);
    cyc(1, 2'd1, 4'b0001, 4'b1000, 0, 0, 0, 0);
    cyc(0, 2'd0, 0, 0, 0, 4'b0001, 0, 0);
    cmp("R4 consumer of ordinary unit killed", kill, 4'b0010);
    cmp("R7 ordinary producer raises no wb_req", wb_req, 4'b0000);
    cmp("R7 ordinary producer still commits", commit_ok, 4'b1000);
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 4'b1000);
    cmp("R8 last unit retires", commit_ok, 4'b0000);
    idle_cyc();

    done = 1;
    summary();
    $finish;
  end
endmodule